// File: doc/BRIEF.md
# Multicore Collatz Delay Register Block

This block puts a set of parallel Collatz step-counting engines behind a word-addressed, memory-mapped slave with a 32-bit data path. There are K = 2^N_SEL engines. Each engine takes a 64-bit start value and repeatedly halves it when it is even, or maps it to 3x+1 when it is odd. It counts the steps until the value reaches 1. The count is a 16-bit delay.

Software loads a start value as two 32-bit writes, lower half first. Writing the upper half launches the addressed engine. Software then polls one shared status word for that engine's done bit and reads the engine's delay. Engines run independently of each other, so software can keep all K of them busy at once and collect each result when its done bit rises.

Top module: `collatz_multicore`

## Requirements
- R1: After reset, every done bit reads 1, every delay reads 0, and rdata_o is 0.
- R2: Word offset 2j holds bits 31..0 of engine j's start value. Word offset 2j+1 supplies bits 63..32. A write to offset 2j+1 loads the combined 64-bit value into engine j, starts it, and clears done bit j when the value is greater than 1.
- R3: An engine maps even x to x/2 and odd x to 3x+1, one step per clock. It sets done when x reaches 1, and the delay equals the number of steps taken. A start value of 1 or 0 completes at once with delay 0.
- R4: A read of offset 2K+j returns engine j's delay in bits 15..0, with bits 31..16 zero.
- R5: A read of offset 3K returns a status word whose bit j is engine j's done flag, with all bits at K and above zero.
- R6: Read data appears on rdata_o in the cycle after rd_i is sampled. In any cycle that does not follow a read, rdata_o is 0.
- R7: Writes to offsets 2K and above leave every delay and done flag unchanged. Reads of offsets above 3K, and reads of the start-value offsets 0..2K-1, return 0.
- R8: Only the addressed engine starts. Every other engine keeps its done flag and its delay.
- R9: A lower-half write alone does not start an engine. The lower half is held until the upper-half write, and the last lower-half value written is the one used.
- R10: An upper-half write to a busy engine abandons the run in progress and restarts the engine from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The start values are chosen to separate the two halves of the step rule and the two halves of the operand:
- Small odd and even values (2, 3, 6, 7) show whether the even and odd steps are applied correctly.
- Long trajectories (27, 97, 871) run past 100 steps, so a counter or mux error accumulates into a wrong delay.
- Powers of two at and above 2^32 fail when the upper word is dropped or placed in the wrong position.
- The values 0 and 1 cover immediate completion.

Vectors rotate across the engines, which catches a core-select that maps offsets to the wrong engine. Directed runs cover overlapping engines, a restart while busy, writes of the lower half only, and offsets that are read-only or out of range.

// File: rtl/collatz_pkg.sv
package collatz_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OPND_LO,
    ACC_OPND_HI,
    ACC_RESULT,
    ACC_STATUS
  } acc_kind_e;
endpackage

// File: rtl/collatz_core.sv
module collatz_core #(
  parameter int OPND_W = 64,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OPND_W-1:0] x0_i,
  output logic              done_o,
  output logic [DLY_W-1:0]  delay_o
);
  localparam logic [OPND_W-1:0] ONE = OPND_W'(1);

  logic [OPND_W-1:0] x_q, x_nxt;
  logic [DLY_W-1:0]  cnt_q;
  logic              done_q;

  always_comb begin
    if (x_q[0]) x_nxt = x_q + (x_q << 1) + ONE;
    else        x_nxt = x_q >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= ONE;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (start_i) begin
      x_q    <= x0_i;
      cnt_q  <= '0;
      done_q <= (x0_i <= ONE);  // 0 and 1 finish at once
    end else if (!done_q) begin
      x_q   <= x_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (x_nxt == ONE) done_q <= 1'b1;
    end
  end

  assign done_o  = done_q;
  assign delay_o = cnt_q;
endmodule

// File: rtl/collatz_addr_decode.sv
module collatz_addr_decode
  import collatz_pkg::*;
#(
  parameter int N_SEL  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [N_SEL-1:0]  sel_o
);
  localparam int K = 1 << N_SEL;
  localparam logic [ADDR_W-1:0] OFF_RES  = ADDR_W'(2 * K);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(3 * K);

  always_comb begin
    kind_o = ACC_NONE;
    sel_o  = '0;
    if (addr_i < OFF_RES) begin
      sel_o  = addr_i[N_SEL:1];
      kind_o = addr_i[0] ? ACC_OPND_HI : ACC_OPND_LO;
    end else if (addr_i < OFF_STAT) begin
      sel_o  = addr_i[N_SEL-1:0];  // 2K is aligned to K
      kind_o = ACC_RESULT;
    end else if (addr_i == OFF_STAT) begin
      kind_o = ACC_STATUS;
    end
  end
endmodule

// File: rtl/collatz_multicore.sv
module collatz_multicore
  import collatz_pkg::*;
#(
  parameter int N_SEL  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int K      = 1 << N_SEL;
  localparam int OPND_W = 2 * DATA_W;

  acc_kind_e         kind;
  logic [N_SEL-1:0]  sel;
  logic [DATA_W-1:0] lo_q [K];
  logic [K-1:0]      start_vec;
  logic [K-1:0]      done_vec;
  logic [DLY_W-1:0]  delay_w [K];
  logic [DATA_W-1:0] rd_mux, rdata_q;

  collatz_addr_decode #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i),
    .kind_o(kind),
    .sel_o (sel)
  );

  for (genvar j = 0; j < K; j++) begin : g_core
    collatz_core #(.OPND_W(OPND_W), .DLY_W(DLY_W)) u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_vec[j]),
      .x0_i   ({wdata_i, lo_q[j]}),
      .done_o (done_vec[j]),
      .delay_o(delay_w[j])
    );
  end

  // decode, core select and read mux
  always_comb begin
    start_vec = '0;
    if (wr_i && kind == ACC_OPND_HI) start_vec[sel] = 1'b1;
    case (kind)
      ACC_RESULT: rd_mux = DATA_W'(delay_w[sel]);
      ACC_STATUS: rd_mux = DATA_W'(done_vec);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < K; j++) lo_q[j] <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && kind == ACC_OPND_LO) lo_q[sel] <= wdata_i;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/collatz_multicore_chk.sv
module collatz_multicore_chk #(
  parameter int K      = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [K-1:0]      start_vec,
  input logic [K-1:0]      done_vec
);
  localparam logic [ADDR_W-1:0] OFF_RES  = ADDR_W'(2 * K);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(3 * K);

  p_idle_rdata_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);

  p_result_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i >= OFF_RES && addr_i < OFF_STAT |=> (rdata_o >> DLY_W) == '0);

  p_status_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFF_STAT |=> (rdata_o >> K) == '0);

  p_out_of_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i > OFF_STAT || addr_i < OFF_RES) |=> rdata_o == '0);

  p_one_core_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_vec));

  for (genvar j = 0; j < K; j++) begin : g_hold
    p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_vec[j] && !start_vec[j] |=> done_vec[j]);
  end
endmodule

bind collatz_multicore collatz_multicore_chk #(
  .K(K), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .start_vec(start_vec),
  .done_vec (done_vec)
);

// File: tb/tb_collatz_multicore.sv
module tb_collatz_multicore;
  localparam int CLK_PERIOD = 10;
  localparam int K = 4;
  localparam int OFF_RES = 2 * K;
  localparam int OFF_STAT = 3 * K;
  localparam int NVEC = 11;
  // {start value, expected delay}
  localparam logic [79:0] VEC [NVEC] = '{
    {64'd1, 16'd0}, {64'd2, 16'd1}, {64'd3, 16'd7}, {64'd6, 16'd8},
    {64'd7, 16'd16}, {64'd27, 16'd111}, {64'd97, 16'd118},
    {64'd871, 16'd178}, {64'h1_0000_0000, 16'd32},
    {64'h100_0000_0000, 16'd40}, {64'd0, 16'd0}
  };

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  int checks = 0, failures = 0, cyc = 0;

  collatz_multicore dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(int a, logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd_word(int a, output logic [31:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = 8'(a);
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic start(int core, logic [63:0] x0);
    wr_word(2 * core, x0[31:0]);
    wr_word(2 * core + 1, x0[63:32]);
  endtask

  task automatic wait_done(int core);
    logic [31:0] s;
    for (int t = 0; t < 1000; t++) begin
      rd_word(OFF_STAT, s);
      if (s[core]) break;
    end
  endtask

  initial begin
    logic [31:0] d, s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 rdata after reset", rdata_o, 32'h0);
    rd_word(OFF_STAT, d);
    chk("R1 status after reset", d, 32'hF);
    for (int j = 0; j < K; j++) begin
      rd_word(OFF_RES + j, d);
      chk("R1 delay after reset", d, 32'h0);
    end

    // table walk, rotating across cores
    for (int i = 0; i < NVEC; i++) begin
      int core = i % K;
      start(core, VEC[i][79:16]);
      if (VEC[i][15:0] >= 2) begin
        rd_word(OFF_STAT, s);
        chk("R2 done cleared on start", 32'(s[core]), 32'h0);
      end
      wait_done(core);
      rd_word(OFF_RES + core, d);
      chk("R3 R4 delay", d, {16'h0, VEC[i][15:0]});
    end

    chk("R6 rdata zero without read", rdata_o, 32'h0);

    // R8: overlapping engines, others untouched
    start(2, 64'd6);
    wait_done(2);
    start(0, 64'd871);
    start(1, 64'd2);
    wait_done(1);
    rd_word(OFF_STAT, s);
    chk("R8 core0 still busy", 32'(s[0]), 32'h0);
    rd_word(OFF_RES + 1, d);
    chk("R8 core1 delay", d, 32'd1);
    rd_word(OFF_RES + 2, d);
    chk("R8 core2 kept", d, 32'd8);
    wait_done(0);
    rd_word(OFF_RES + 0, d);
    chk("R8 core0 delay", d, 32'd178);

    // R10: restart while busy
    start(3, 64'd871);
    start(3, 64'd7);
    wait_done(3);
    rd_word(OFF_RES + 3, d);
    chk("R10 restart delay", d, 32'd16);

    // R9: lower half only, then last value wins
    wr_word(2, 32'd5);
    rd_word(OFF_STAT, s);
    chk("R9 lo write does not start", s, 32'hF);
    wr_word(2, 32'd27);
    wr_word(3, 32'd0);
    wait_done(1);
    rd_word(OFF_RES + 1, d);
    chk("R9 latest lo used", d, 32'd111);

    // R7: read-only and out-of-range offsets
    wr_word(OFF_RES + 1, 32'hFFFF_FFFF);
    wr_word(OFF_STAT, 32'h0);
    wr_word(OFF_STAT + 1, 32'hFFFF_FFFF);
    rd_word(OFF_RES + 1, d);
    chk("R7 result write ignored", d, 32'd111);
    rd_word(OFF_STAT, s);
    chk("R7 R5 status write ignored", s, 32'hF);
    rd_word(OFF_STAT + 1, d);
    chk("R7 out-of-range read", d, 32'h0);
    rd_word(0, d);
    chk("R7 operand read zero", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule